// File: doc/BRIEF.md
# Vector Condition Result Bit Packer

This block walks over a vector of up to 64 elements and gathers one small test result per element into 64-bit integer destination registers. On each element it puts out the address of one condition field. A companion mask-mode unit turns that field into a result in the same cycle, and the packer takes the result at the next clock edge. A result is either one bit (bit 0 of the returned nibble) or all four bits.

The source element-width code does not choose an operand size. It chooses how many results share one destination integer: 1, 2, 4 or 8. Results are packed from the least significant end, and every bit above the packed results is zero. With a scalar destination, all results go into register offset 0, one bit or one nibble per element. Sixteen nibbles fill that register, so a longer vector is cut to 16 elements and flagged.

Each destination register is written exactly once, with its complete value. The write happens when the register's last slot is filled or when the final element arrives. A done pulse follows the final write by one cycle.

Top module: `vec_cond_packer`

## Requirements
- R1: While reset is held and right after it is released, busy_o, fld_req_o, wr_en_o, done_o and vl_over_o are all 0.
- R2: With src_vec_i=1, element i requests field address src_base_i+i (modulo 128). With src_vec_i=0, every element requests src_base_i.
- R3: For a vector destination, src_ew_i codes 00, 01, 10 and 11 place K = 1, 2, 4 and 8 results in each destination register. Element i goes to register offset i/K.
- R4: With one-bit results (res_wide_i=0) and dst_vec_i=1, fld_res_i[0] of element i lands at LSB-numbered bit i%K of its register. Every bit at K or above is 0.
- R5: With one-bit results and dst_vec_i=0, every write uses offset 0 and element i lands at bit i.
- R6: With four-bit results (res_wide_i=1), fld_res_i[3:0] of element i fills bits 4·s to 4·s+3, where s = i%K for a vector destination and s = i for a scalar one.
- R7: With res_wide_i=1, dst_vec_i=0 and vl_i above 16, only 16 elements are processed and vl_over_o is 1 in the done cycle. In every other case vl_over_o stays 0. vl_i values above 64 are treated as 64.
- R8: Each destination register gets exactly one write, carrying its full 64-bit value. The write comes in the cycle after the element that fills the register's last slot, or after the final element. Writes come in increasing offset order.
- R9: done_o is a one-cycle pulse that comes one cycle after the final write. busy_o is 1 from the cycle after an accepted start until the done cycle.
- R10: A start_i that arrives while busy_o is 1 is ignored. The running operation's requests, writes and single done pulse do not change.
- R11: A start with vl_i=0 makes no requests and no writes, and raises done_o in the next cycle.
- R12: fld_req_o is 1 for exactly as many consecutive cycles as there are processed elements, starting in the cycle after start is accepted. fld_res_i is sampled in the same cycle as its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | 7 | Vector length, 0 to 64 |
| src_base_i | input | 7 | Base condition-field index |
| src_vec_i | input | 1 | 1: source field steps by one per element; 0: fixed field |
| src_ew_i | input | 2 | Packing code: 1, 2, 4 or 8 results per destination register |
| res_wide_i | input | 1 | 0: one-bit results; 1: four-bit results |
| dst_vec_i | input | 1 | 1: vector destination; 0: all results in offset 0 |
| fld_req_o | output | 1 | A field address is presented this cycle |
| fld_addr_o | output | 7 | Condition-field read address |
| fld_res_i | input | 4 | Result from the companion unit for the current address |
| wr_en_o | output | 1 | Integer write request |
| wr_off_o | output | 6 | Destination register offset |
| wr_data_o | output | 64 | Fully assembled register value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| vl_over_o | output | 1 | Set with done when a scalar four-bit run was cut to 16 elements |

## Verification
The bench aims at the register boundaries for every packing code, using vector lengths that leave the last register part-filled. A block that decoded the code wrongly, or failed to flush a partial register, would write the wrong offsets or drop the tail of the vector. Scalar destinations are run at exactly 16 and at 20 nibbles, and at 37 and 64 single bits. An off-by-one cap would either take a 17th request or raise the over-length flag at 16. A zero-length start and a start poked in mid-run check that done is neither late nor doubled. Scalar-source runs check that the address never steps, and the upper-bit checks catch stale accumulator bits leaking into the next register.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  localparam int DATA_W    = 64;
  localparam int NIB       = 4;
  localparam int FA_W      = 7;
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int VL_W      = IDX_W + 1;
  localparam int NIB_SLOTS = DATA_W / NIB;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } vcp_state_e;

  typedef struct packed {
    logic [FA_W-1:0]  base;
    logic             src_vec;
    logic [1:0]       ew;
    logic             wide;
    logic             dst_vec;
    logic [IDX_W-1:0] last;
    logic             over;
  } vcp_cfg_t;
endpackage

// File: rtl/vcp_rst_sync.sv
module vcp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/vcp_ctrl.sv
module vcp_ctrl
  import vcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [FA_W-1:0]  base_i,
  input  logic             src_vec_i,
  input  logic [1:0]       ew_i,
  input  logic             wide_i,
  input  logic             dst_vec_i,
  output logic [FA_W-1:0]  base_o,
  output logic             src_vec_o,
  output logic [1:0]       ew_o,
  output logic             wide_o,
  output logic             dst_vec_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             run_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             over_o
);
  localparam logic [VL_W-1:0] VL_MAX  = VL_W'(DATA_W);
  localparam logic [VL_W-1:0] NIB_CAP = VL_W'(NIB_SLOTS);

  vcp_state_e       st_q, st_d;
  vcp_cfg_t         cfg_q, cfg_d;
  logic             cfg_en;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             over_q, over_d;
  logic [VL_W-1:0]  vl_clip, vl_eff, vl_m1;
  logic             cap_hit, accept;

  always_comb begin
    vl_clip = (vl_i > VL_MAX) ? VL_MAX : vl_i;
    cap_hit = !dst_vec_i && wide_i && (vl_clip > NIB_CAP);
    vl_eff  = cap_hit ? NIB_CAP : vl_clip;
    vl_m1   = vl_eff - VL_W'(1);
    accept  = start_i && (st_q == ST_IDLE);

    cfg_d.base    = base_i;
    cfg_d.src_vec = src_vec_i;
    cfg_d.ew      = ew_i;
    cfg_d.wide    = wide_i;
    cfg_d.dst_vec = dst_vec_i;
    cfg_d.last    = vl_m1[IDX_W-1:0];
    cfg_d.over    = cap_hit;
  end

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cfg_en = 1'b0;
    done_d = 1'b0;
    over_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (vl_eff == '0) begin
            done_d = 1'b1;
          end else begin
            st_d   = ST_RUN;
            idx_d  = '0;
            cfg_en = 1'b1;
          end
        end
      end
      ST_RUN: begin
        idx_d = idx_q + IDX_W'(1);
        if (idx_q == cfg_q.last) st_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        over_d = cfg_q.over;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      over_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
      over_q <= over_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign base_o    = cfg_q.base;
  assign src_vec_o = cfg_q.src_vec;
  assign ew_o      = cfg_q.ew;
  assign wide_o    = cfg_q.wide;
  assign dst_vec_o = cfg_q.dst_vec;
  assign idx_o     = idx_q;
  assign run_o     = (st_q == ST_RUN);
  assign last_o    = (idx_q == cfg_q.last);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign over_o    = over_q;
endmodule

// File: rtl/vcp_slot.sv
module vcp_slot
  import vcp_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       ew_i,
  input  logic             dst_vec_i,
  output logic [IDX_W-1:0] slot_o,
  output logic [IDX_W-1:0] off_o,
  output logic             full_o
);
  logic [IDX_W-1:0] kmask;

  always_comb begin
    kmask = (IDX_W'(1) << ew_i) - IDX_W'(1);
    if (dst_vec_i) begin
      slot_o = idx_i & kmask;
      off_o  = idx_i >> ew_i;
      full_o = ((idx_i & kmask) == kmask);
    end else begin
      slot_o = idx_i;
      off_o  = '0;
      full_o = 1'b0;
    end
  end
endmodule

// File: rtl/vcp_place.sv
module vcp_place
  import vcp_pkg::*;
(
  input  logic [IDX_W-1:0]  slot_i,
  input  logic              wide_i,
  input  logic [NIB-1:0]    res_i,
  output logic [DATA_W-1:0] placed_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam logic [IDX_W-1:0] NSLOT = IDX_W'(b / NIB);
    localparam logic [IDX_W-1:0] BSLOT = IDX_W'(b);
    assign placed_o[b] = wide_i ? ((slot_i == NSLOT) & res_i[b % NIB])
                                : ((slot_i == BSLOT) & res_i[0]);
  end
endmodule

// File: rtl/vec_cond_packer.sv
module vec_cond_packer
  import vcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [FA_W-1:0]   src_base_i,
  input  logic              src_vec_i,
  input  logic [1:0]        src_ew_i,
  input  logic              res_wide_i,
  input  logic              dst_vec_i,
  output logic              fld_req_o,
  output logic [FA_W-1:0]   fld_addr_o,
  input  logic [NIB-1:0]    fld_res_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_off_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              vl_over_o
);
  logic              rst_sn;
  logic [FA_W-1:0]   c_base;
  logic              c_src_vec, c_wide, c_dst_vec;
  logic [1:0]        c_ew;
  logic [IDX_W-1:0]  idx, slot, off;
  logic              run, last, full, flush;
  logic [DATA_W-1:0] placed, merged;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              wr_en_q, wr_en_d;
  logic [IDX_W-1:0]  wr_off_q, wr_off_d;
  logic [DATA_W-1:0] wr_data_q, wr_data_d;

  vcp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sn)
  );

  vcp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sn),
    .start_i   (start_i),
    .vl_i      (vl_i),
    .base_i    (src_base_i),
    .src_vec_i (src_vec_i),
    .ew_i      (src_ew_i),
    .wide_i    (res_wide_i),
    .dst_vec_i (dst_vec_i),
    .base_o    (c_base),
    .src_vec_o (c_src_vec),
    .ew_o      (c_ew),
    .wide_o    (c_wide),
    .dst_vec_o (c_dst_vec),
    .idx_o     (idx),
    .run_o     (run),
    .last_o    (last),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .over_o    (vl_over_o)
  );

  vcp_slot u_slot (
    .idx_i     (idx),
    .ew_i      (c_ew),
    .dst_vec_i (c_dst_vec),
    .slot_o    (slot),
    .off_o     (off),
    .full_o    (full)
  );

  vcp_place u_place (
    .slot_i   (slot),
    .wide_i   (c_wide),
    .res_i    (fld_res_i),
    .placed_o (placed)
  );

  assign fld_req_o  = run;
  assign fld_addr_o = c_base + (c_src_vec ? FA_W'(idx) : FA_W'(0));

  always_comb begin
    merged    = acc_q | placed;
    flush     = run && (full || last);
    acc_d     = acc_q;
    wr_en_d   = 1'b0;
    wr_off_d  = wr_off_q;
    wr_data_d = wr_data_q;
    if (run) begin
      if (flush) begin
        acc_d     = '0;
        wr_en_d   = 1'b1;
        wr_off_d  = off;
        wr_data_d = merged;
      end else begin
        acc_d = merged;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_q   <= '0;
      wr_en_q <= 1'b0;
    end else begin
      if (run) acc_q <= acc_d;
      wr_en_q <= wr_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      wr_off_q  <= '0;
      wr_data_q <= '0;
    end else if (flush) begin
      wr_off_q  <= wr_off_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_off_o  = wr_off_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/vcp_checker.sv
module vcp_checker
  import vcp_pkg::*;
(
  input logic              clk,
  input logic              rst_sn,
  input logic              busy_o,
  input logic              done_o,
  input logic              fld_req_o,
  input logic [FA_W-1:0]   fld_addr_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              c_src_vec,
  input logic              c_dst_vec,
  input logic              c_wide,
  input logic [1:0]        c_ew
);
  logic [DATA_W-1:0] low_mask;
  assign low_mask = (DATA_W'(1) << (4'd1 << c_ew)) - DATA_W'(1);

  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    fld_req_o |-> busy_o);

  p_scalar_addr_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (fld_req_o && $past(fld_req_o) && !c_src_vec) |-> $stable(fld_addr_o));

  p_vector_addr_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (fld_req_o && $past(fld_req_o) && c_src_vec) |-> (fld_addr_o == $past(fld_addr_o) + FA_W'(1)));

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_en_o && c_dst_vec && !c_wide) |-> ((wr_data_o & ~low_mask) == '0));

  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_en_o |-> busy_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o);

  p_done_at_end_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy_o) |-> done_o);

  p_no_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> !busy_o);
endmodule

bind vec_cond_packer vcp_checker u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fld_req_o  (fld_req_o),
  .fld_addr_o (fld_addr_o),
  .wr_en_o    (wr_en_o),
  .wr_data_o  (wr_data_o),
  .c_src_vec  (c_src_vec),
  .c_dst_vec  (c_dst_vec),
  .c_wide     (c_wide),
  .c_ew       (c_ew)
);

// File: tb/vec_cond_packer_test.sv
`timescale 1ns/1ps
module vec_cond_packer_test;
  localparam real HALF = 2.5;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [6:0]  vl_i;
  logic [6:0]  src_base_i;
  logic        src_vec_i;
  logic [1:0]  src_ew_i;
  logic        res_wide_i;
  logic        dst_vec_i;
  logic        fld_req_o;
  logic [6:0]  fld_addr_o;
  logic [3:0]  fld_res_i;
  logic        wr_en_o;
  logic [5:0]  wr_off_o;
  logic [63:0] wr_data_o;
  logic        busy_o;
  logic        done_o;
  logic        vl_over_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  vec_cond_packer uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
    .src_base_i(src_base_i), .src_vec_i(src_vec_i), .src_ew_i(src_ew_i),
    .res_wide_i(res_wide_i), .dst_vec_i(dst_vec_i), .fld_req_o(fld_req_o),
    .fld_addr_o(fld_addr_o), .fld_res_i(fld_res_i), .wr_en_o(wr_en_o),
    .wr_off_o(wr_off_o), .wr_data_o(wr_data_o), .busy_o(busy_o),
    .done_o(done_o), .vl_over_o(vl_over_o)
  );

  function automatic logic [3:0] comp_res(input logic [6:0] a);
    logic [7:0] t;
    t = {1'b0, a} * 8'd37 + 8'd11;
    return t[6:3];
  endfunction

  // companion mask-mode unit model: combinational result for the presented address
  assign fld_res_i = comp_res(fld_addr_o);

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int vl, input int base, input bit sv, input int ew,
                        input bit wide, input bit dv, input bit poke,
                        input string dtag, output int done_cnt);
    int n, k, ne, nreq, nwr, done_c, last_wr_c, c, after;
    logic [63:0] acc;
    logic [63:0] exp_data [64];
    int          exp_off  [64];
    logic [63:0] got_data [64];
    int          got_off  [64];
    int          got_addr [64];
    int          first_req_c;
    bit          over_seen, exp_over, addr_ok, tmo;
    n = (vl > 64) ? 64 : vl;
    exp_over = 0;
    if (!dv && wide && n > 16) begin n = 16; exp_over = 1; end
    k = dv ? (1 << ew) : (wide ? 16 : 64);
    acc = '0; ne = 0;
    for (int i = 0; i < n; i++) begin
      int slot, off;
      logic [3:0] r;
      logic [6:0] a;
      slot = dv ? (i % k) : i;
      off  = dv ? (i / k) : 0;
      a = 7'((base + (sv ? i : 0)) % 128);
      r = comp_res(a);
      if (wide) acc = acc | (64'(r) << (4 * slot));
      else      acc = acc | (64'(r[0]) << slot);
      if (slot == k - 1 || i == n - 1) begin
        exp_off[ne] = off; exp_data[ne] = acc; ne++; acc = '0;
      end
    end
    @(negedge clk);
    vl_i = 7'(vl); src_base_i = 7'(base); src_vec_i = sv; src_ew_i = 2'(ew);
    res_wide_i = wide; dst_vec_i = dv; start_i = 1'b1;
    nreq = 0; nwr = 0; done_c = -1; done_cnt = 0; last_wr_c = -1; first_req_c = -1;
    over_seen = 0; after = 0; c = 0; tmo = 0; addr_ok = 1;
    while (1) begin
      @(negedge clk);
      if (fld_req_o) begin
        if (first_req_c < 0) first_req_c = c;
        if (nreq < 64) got_addr[nreq] = int'(fld_addr_o);
        nreq++;
      end
      if (wr_en_o) begin
        if (nwr < 64) begin got_off[nwr] = int'(wr_off_o); got_data[nwr] = wr_data_o; end
        nwr++; last_wr_c = c;
      end
      if (vl_over_o) over_seen = 1;
      if (done_o) begin done_cnt++; if (done_c < 0) done_c = c; end
      if (c == 0) start_i = 1'b0;
      if (poke && c == 2) begin start_i = 1'b1; vl_i = 7'd0; end
      if (poke && c == 3) begin start_i = 1'b0; vl_i = 7'(vl); end
      if (done_c >= 0) after++;
      if (after > 3) break;
      c++;
      if (c > 300) begin tmo = 1; break; end
    end
    check(!tmo, "R9", {dtag, " run finished"}, 0, 0);
    check(nreq == n, "R12", {dtag, " request count"}, nreq, n);
    if (n > 0) begin
      check(first_req_c == 0, "R12", {dtag, " first request cycle"}, first_req_c, 0);
      for (int i = 0; i < n && i < 64; i++)
        if (got_addr[i] != (base + (sv ? i : 0)) % 128) addr_ok = 0;
      check(addr_ok, "R2", {dtag, " field addresses"}, got_addr[n-1], (base + (sv ? n-1 : 0)) % 128);
    end
    check(nwr == ne, "R8", {dtag, " write count"}, nwr, ne);
    for (int i = 0; i < ne && i < nwr; i++) begin
      check(got_off[i] == exp_off[i], "R3", {dtag, " write offset"}, got_off[i], exp_off[i]);
      check(got_data[i] == exp_data[i], dtag, "write data", got_data[i], exp_data[i]);
    end
    check(done_cnt == 1, "R9", {dtag, " done pulses"}, done_cnt, 1);
    if (n > 0)
      check(done_c == last_wr_c + 1, "R9", {dtag, " done after final write"}, done_c, last_wr_c + 1);
    else
      check(done_c == 0, "R11", {dtag, " zero-length done cycle"}, done_c, 0);
    check(over_seen == exp_over, "R7", {dtag, " over-length flag"}, over_seen, exp_over);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(!busy_o && !fld_req_o && !wr_en_o && !done_o && !vl_over_o, "R1",
          "outputs idle after reset", {busy_o, fld_req_o, wr_en_o, done_o, vl_over_o}, 0);
  endtask

  task automatic test_vec_one_bit();
    int d;
    for (int ew = 0; ew < 4; ew++) run_op(11, 5, 1, ew, 0, 1, 0, "R4", d);
    run_op(64, 100, 1, 3, 0, 1, 0, "R4", d);
  endtask

  task automatic test_scalar_src();
    int d;
    run_op(9, 42, 0, 1, 0, 1, 0, "R4", d);
    run_op(6, 17, 0, 2, 1, 1, 0, "R6", d);
  endtask

  task automatic test_scalar_dst_bits();
    int d;
    run_op(37, 3, 1, 2, 0, 0, 0, "R5", d);
    run_op(64, 77, 1, 0, 0, 0, 0, "R5", d);
  endtask

  task automatic test_nibbles();
    int d;
    run_op(10, 20, 1, 2, 1, 1, 0, "R6", d);
    run_op(19, 64, 1, 3, 1, 1, 0, "R6", d);
    run_op(3, 9, 1, 0, 1, 1, 0, "R6", d);
  endtask

  task automatic test_scalar_nibble_cap();
    int d;
    run_op(16, 30, 1, 0, 1, 0, 0, "R6", d);
    run_op(20, 30, 1, 0, 1, 0, 0, "R7", d);
  endtask

  task automatic test_zero_len();
    int d;
    run_op(0, 8, 1, 1, 0, 1, 0, "R11", d);
    check(!busy_o && !wr_en_o, "R11", "idle after zero-length run", busy_o, 0);
  endtask

  task automatic test_busy_start();
    int d;
    run_op(12, 50, 1, 1, 0, 1, 1, "R4", d);
    check(d == 1, "R10", "start while busy ignored", d, 1);
  endtask

  initial begin
    #(HALF * 2 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL R9 watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; vl_i = '0; src_base_i = '0; src_vec_i = 1'b0;
    src_ew_i = '0; res_wide_i = 1'b0; dst_vec_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o && !fld_req_o && !wr_en_o && !done_o, "R1", "outputs during reset", busy_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_vec_one_bit();
    test_scalar_src();
    test_scalar_dst_bits();
    test_nibbles();
    test_scalar_nibble_cap();
    test_zero_len();
    test_busy_start();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule